// File: doc/BRIEF.md
# Dual-Port Remote Interrupt Router

The block takes interrupt levels from two remote receiver ports and drives two active-low interrupt pins toward a host: a remote pin and a main pin. A 4-bit route field picks one of two routings. In the combined routing, either port asserts the remote pin. In the split routing, port 0 alone drives the remote pin, and port 1 drives the main pin. The main pin also carries locally generated security-engine interrupts, gated by an enable register.

In the split routing the two ports behave differently. Port 0 is a plain inverted level with no memory. Port 1 sets a sticky flag on a rising edge. A host read of the status register clears that flag, but only if the port 1 level has already gone low. The remote levels arrive asynchronously and pass through a two-flop synchronizer. A port whose link flag is low counts as idle.

Top module: `dual_irq_router`

## Requirements
- R1: After reset both pins are high, the route register (0x30), the enable register (0xC6) and the local status are zero, and the port 1 flag is clear.
- R2: A remote level passes two synchronizer flops and an output flop, so the remote pin responds on the third rising clock edge after the input changes.
- R3: When the route field (bits [3:0] of 0x30) is not 4'b0001, the remote pin is low exactly when either port has a high synchronized level with its link flag set. Port 1 then has no effect on the main pin.
- R4: When the route field is 4'b0001, the remote pin is the inverse of port 0's synchronized, link-qualified level, with no latching.
- R5: In split routing, a low-to-high change of port 1's link-qualified level sets the port 1 flag on the next edge. The main pin goes low one edge later and stays low after the input falls.
- R6: A read of address 0xC7 clears the port 1 flag when port 1's qualified level is low in that cycle. The main pin rises one edge later if no enabled local status remains.
- R7: A read of 0xC7 while port 1's qualified level is high leaves the flag set.
- R8: A low link flag forces that port's contribution inactive on both pins, and a low port 1 link flag clears the port 1 flag. Leaving split routing also clears the flag.
- R9: Each local source pulse sets a sticky status bit. A status bit pulls the main pin low, one edge after it is set, only while its enable bit (0xC6 bit i) is 1.
- R10: A read of 0xC7 clears all local status bits on the same edge that evaluates the port 1 flag. A local pulse in that same cycle wins, and its bit stays set.
- R11: Reads return data in the same cycle. 0x30 and 0xC6 read back the full written byte. 0xC7 returns the port 1 flag in bit 7 and the local status in bits [LOC_N-1:0], with zeros elsewhere. Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rmt_irq_i | input | 2 | Remote interrupt levels, bit p = port p, asynchronous |
| link_ok_i | input | 2 | Per-port link valid flags, synchronous |
| loc_irq_i | input | LOC_N | Local security-engine interrupt pulses |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_addr_i | input | 8 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational |
| rem_irq_no | output | 1 | Remote interrupt pin, active low |
| main_irq_no | output | 1 | Main interrupt pin, active low |

## Verification
A status read at 0xC7 can fall in the same cycle as a port 1 rising edge, or as a fresh local pulse. The flag and the status bits must each resolve in favour of the new event. The bench provokes both collisions with directed reads issued while the port 1 level is still high, and while a local pulse is being driven. Random reads then keep landing on edges and pulses. A cycle-accurate reference model in the bench judges every pin and every read-data value.

// File: rtl/irq_rt_pkg.sv
package irq_rt_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;
  localparam logic [ADDR_W-1:0] ADDR_ROUTE  = 8'h30;
  localparam logic [ADDR_W-1:0] ADDR_LOC_EN = 8'hC6;
  localparam logic [ADDR_W-1:0] ADDR_STS    = 8'hC7;
  localparam logic [3:0] ROUTE_SPLIT = 4'b0001;
  localparam int STS_FLAG_BIT = 7;
endpackage

// File: rtl/irq_rt_sync.sv
module irq_rt_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/irq_rt_regs.sv
module irq_rt_regs
  import irq_rt_pkg::*;
#(
  parameter int LOC_N = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [LOC_N-1:0]  loc_irq_i,
  input  logic              p1_flag_i,
  output logic              split_o,
  output logic              loc_pend_o,
  output logic              rd_sts_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int STS_W = (LOC_N < STS_FLAG_BIT) ? LOC_N : STS_FLAG_BIT;

  logic [DATA_W-1:0] route_q, en_q;
  logic [LOC_N-1:0]  sts_q;
  logic [DATA_W-1:0] sts_word;

  assign rd_sts_o = re_i && (addr_i == ADDR_STS);
  assign split_o  = (route_q[3:0] == ROUTE_SPLIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      route_q <= '0;
      en_q    <= '0;
    end else if (we_i) begin
      if (addr_i == ADDR_ROUTE)  route_q <= wdata_i;
      if (addr_i == ADDR_LOC_EN) en_q    <= wdata_i;
    end
  end

  // new pulses win over the clearing read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_q <= '0;
    else         sts_q <= (rd_sts_o ? '0 : sts_q) | loc_irq_i;
  end

  assign loc_pend_o = |(sts_q & en_q[LOC_N-1:0]);

  always_comb begin
    sts_word = '0;
    sts_word[STS_W-1:0] = sts_q[STS_W-1:0];
    sts_word[STS_FLAG_BIT] = p1_flag_i;
  end

  always_comb begin
    rdata_o = '0;
    if (re_i) begin
      unique case (addr_i)
        ADDR_ROUTE:  rdata_o = route_q;
        ADDR_LOC_EN: rdata_o = en_q;
        ADDR_STS:    rdata_o = sts_word;
        default:     rdata_o = '0;
      endcase
    end
  end

  // R10
  sts_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_sts_o && loc_irq_i == '0) |=> sts_q == '0);
  // R11
  route_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_ROUTE) |=> route_q == $past(wdata_i));
endmodule

// File: rtl/irq_rt_p1_latch.sv
module irq_rt_p1_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic split_i,
  input  logic link_i,
  input  logic lvl_i,
  input  logic rd_clr_i,
  output logic flag_o
);
  logic eff, eff_q, flag_q;

  assign eff = lvl_i & link_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eff_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      eff_q <= eff;
      if (!link_i || !split_i)  flag_q <= 1'b0;
      else if (eff && !eff_q)   flag_q <= 1'b1;
      else if (rd_clr_i && !eff) flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;

  // R7
  held_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr_i && eff && flag_q && link_i && split_i) |=> flag_q);
  // R5
  rise_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (split_i && link_i && eff && !eff_q) |=> flag_q);
endmodule

// File: rtl/dual_irq_router.sv
module dual_irq_router
  import irq_rt_pkg::*;
#(
  parameter int LOC_N       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        rmt_irq_i,
  input  logic [1:0]        link_ok_i,
  input  logic [LOC_N-1:0]  loc_irq_i,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              rem_irq_no,
  output logic              main_irq_no
);
  localparam int PORTS = 2;

  logic [PORTS-1:0] lvl_s, eff;
  logic split, loc_pend, rd_sts, p1_flag;
  logic rem_q, main_q;

  irq_rt_sync #(.W(PORTS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(rmt_irq_i), .q_o(lvl_s)
  );

  assign eff = lvl_s & link_ok_i;

  irq_rt_regs #(.LOC_N(LOC_N)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .re_i(reg_re_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .loc_irq_i, .p1_flag_i(p1_flag),
    .split_o(split), .loc_pend_o(loc_pend), .rd_sts_o(rd_sts), .rdata_o(reg_rdata_o)
  );

  irq_rt_p1_latch u_p1 (
    .clk_i, .rst_ni, .split_i(split), .link_i(link_ok_i[1]),
    .lvl_i(lvl_s[1]), .rd_clr_i(rd_sts), .flag_o(p1_flag)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= 1'b1;
      main_q <= 1'b1;
    end else begin
      rem_q  <= split ? ~eff[0] : ~(|eff);
      main_q <= ~(p1_flag | loc_pend);
    end
  end

  assign rem_irq_no  = rem_q;
  assign main_irq_no = main_q;

  // R5
  flag_to_pin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(p1_flag) |=> !main_irq_no);
  // R8
  link_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !link_ok_i[1] |=> !p1_flag);
  // R3
  idle_links_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_ok_i == 2'b00) |=> rem_irq_no);
  // R9
  main_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!p1_flag && !loc_pend) |=> main_irq_no);
endmodule

// File: tb/dual_irq_router_tb_top.sv
module dual_irq_router_tb_top;
  localparam int LOC_N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] rmt = '0, link = 2'b11;
  logic [LOC_N-1:0] loc = '0;
  logic we = 1'b0, re = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic [7:0] rdata;
  logic rem_n, main_n;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;
  bit pin_chk_on = 1'b0;

  always #5 clk = ~clk;

  dual_irq_router #(.LOC_N(LOC_N)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rmt_irq_i(rmt), .link_ok_i(link), .loc_irq_i(loc),
    .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .rem_irq_no(rem_n), .main_irq_no(main_n)
  );

  // reference model
  logic [1:0] m_s1, m_s2, m_eff;
  logic m_eq, m_flag, m_rem, m_main, m_split, m_rd;
  logic [7:0] m_route, m_en;
  logic [LOC_N-1:0] m_sts;

  always_comb begin
    m_eff   = m_s2 & link;
    m_split = (m_route[3:0] == 4'b0001);
    m_rd    = re && (addr == 8'hC7);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_eq <= 1'b0; m_flag <= 1'b0;
      m_rem <= 1'b1; m_main <= 1'b1; m_route <= '0; m_en <= '0; m_sts <= '0;
    end else begin
      m_s1 <= rmt;
      m_s2 <= m_s1;
      m_eq <= m_eff[1];
      if (!link[1] || !m_split)    m_flag <= 1'b0;
      else if (m_eff[1] && !m_eq)  m_flag <= 1'b1;
      else if (m_rd && !m_eff[1])  m_flag <= 1'b0;
      m_sts <= (m_rd ? '0 : m_sts) | loc;
      if (we && addr == 8'h30) m_route <= wdata;
      if (we && addr == 8'hC6) m_en <= wdata;
      m_rem  <= m_split ? ~m_eff[0] : ~(|m_eff);
      m_main <= ~(m_flag | (|(m_sts & m_en[LOC_N-1:0])));
    end
  end

  function automatic logic [7:0] exp_rdata(input logic [7:0] a);
    logic [7:0] v;
    v = '0;
    case (a)
      8'h30: v = m_route;
      8'hC6: v = m_en;
      8'hC7: begin v[LOC_N-1:0] = m_sts; v[7] = m_flag; end
      default: v = '0;
    endcase
    return v;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && pin_chk_on) begin
      chk(m_split ? "R4 remote pin" : "R3 remote pin", {7'd0, rem_n}, {7'd0, m_rem});
      chk("R5 main pin", {7'd0, main_n}, {7'd0, m_main});
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    we = 1'b1; addr = a; wdata = d;
    step(1);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input string tag, output logic [7:0] d);
    re = 1'b1; addr = a;
    #2;
    d = rdata;
    chk(tag, rdata, exp_rdata(a));
    step(1);
    re = 1'b0;
  endtask

  initial begin
    logic [7:0] d;
    void'($urandom(32'h5EED_1234));
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    chk("R1 remote pin", {7'd0, rem_n}, 8'd1);
    chk("R1 main pin", {7'd0, main_n}, 8'd1);
    rd(8'h30, "R1 route reg", d); chk("R1 route zero", d, 8'h00);
    rd(8'hC7, "R1 status", d);    chk("R1 status zero", d, 8'h00);
    pin_chk_on = 1'b1;

    // R11 register map
    wr(8'h30, 8'hA1);
    rd(8'h30, "R11 route readback", d); chk("R11 route value", d, 8'hA1);
    rd(8'h55, "R11 unmapped", d);       chk("R11 unmapped zero", d, 8'h00);

    // R2 / R4 split: port 0 inverted, not latched
    rmt[0] = 1'b1;
    step(2); chk("R2 latency two edges", {7'd0, rem_n}, 8'd1);
    step(1); chk("R2 latency third edge", {7'd0, rem_n}, 8'd0);
    rmt[0] = 1'b0;
    step(3); chk("R4 no latch", {7'd0, rem_n}, 8'd1);

    // R5 / R7 port 1 rising edge, read while still high
    rmt[1] = 1'b1;
    step(3); chk("R5 before flag reaches pin", {7'd0, main_n}, 8'd1);
    step(1); chk("R5 latched low", {7'd0, main_n}, 8'd0);
    rd(8'hC7, "R11 flag bit", d); chk("R11 flag in bit 7", d, 8'h80);
    step(2); chk("R7 read while high keeps flag", {7'd0, main_n}, 8'd0);
    rmt[1] = 1'b0;
    step(5); chk("R5 stays low after input falls", {7'd0, main_n}, 8'd0);
    rd(8'hC7, "R6 status read", d);
    step(1); chk("R6 read clears flag", {7'd0, main_n}, 8'd1);

    // R8 link drop
    rmt[1] = 1'b1;
    step(5); chk("R8 setup latched", {7'd0, main_n}, 8'd0);
    link[1] = 1'b0;
    step(2); chk("R8 link drop clears flag", {7'd0, main_n}, 8'd1);
    rmt[1] = 1'b0; link[1] = 1'b1;
    step(3);
    wr(8'h30, 8'h00);
    rmt[0] = 1'b1; link[0] = 1'b0;
    step(4); chk("R8 masked port 0", {7'd0, rem_n}, 8'd1);
    link[0] = 1'b1;
    step(2); chk("R3 combined port 0", {7'd0, rem_n}, 8'd0);
    rmt = 2'b10;
    step(4); chk("R3 combined port 1", {7'd0, rem_n}, 8'd0);
    chk("R3 port 1 off main pin", {7'd0, main_n}, 8'd1);
    rmt = 2'b00;
    step(4);

    // R9 local sources gated by enable
    loc = 4'b0001; step(1); loc = '0;
    step(2); chk("R9 disabled source", {7'd0, main_n}, 8'd1);
    rd(8'hC7, "R9 status set", d); chk("R9 sticky bit", d, 8'h01);
    wr(8'hC6, 8'h01);
    loc = 4'b0001; step(1); loc = '0;
    step(1); chk("R9 enabled source", {7'd0, main_n}, 8'd0);

    // R10 read colliding with a new pulse
    loc = 4'b0001;
    rd(8'hC7, "R10 read with pulse", d);
    loc = '0;
    step(2); chk("R10 pulse wins", {7'd0, main_n}, 8'd0);
    rd(8'hC7, "R10 status survives", d); chk("R10 bit kept", d, 8'h01);
    step(1); chk("R10 cleared", {7'd0, main_n}, 8'd1);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 6 == 0) rmt[$urandom % 2] ^= 1'b1;
      if ($urandom % 50 == 0) link[$urandom % 2] ^= 1'b1;
      if (link != 2'b11 && $urandom % 8 == 0) link = 2'b11;
      loc = ($urandom % 10 == 0) ? LOC_N'($urandom) : '0;
      case ($urandom % 40)
        0: wr(8'h30, ($urandom % 3 == 0) ? 8'h00 : 8'h01);
        1: wr(8'hC6, 8'($urandom));
        2, 3, 4, 5: rd(8'hC7, "R10 random status read", d);
        6: rd(8'h30, "R11 random route read", d);
        default: step(1);
      endcase
    end
    loc = '0;
    step(2);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule